// File: doc/BRIEF.md
# Edge/Level Interrupt Routing Controller

This block gathers 64 interrupt request lines and forwards them to a bank of parent interrupt outputs. Each line is set up as edge-triggered or level-triggered. The block keeps a pending set, an in-service set and the last-seen level of every line. When a line becomes eligible (pending and unmasked), the block marks it in service and raises the parent output that the line's 8-bit vector entry selects. When an in-service line loses its pending state, the block lowers that parent output again. A parent output is a stored flag: a rising dispatch sets it and a falling dispatch clears it.

Software uses a small register port. Writes are 32-bit words; the 64-bit registers are written as a low half at +0 and a high half at +4. Reads are sized (1, 2, 4 or 8 bytes) and combinational. Through this port software sets the mask, the edge select, a polarity word (stored only), the vector table and the edge-clear register, and it reads a status word. The register map is `0x000` mask, `0x008` edge select, `0x010` clear (write only), `0x018` status, `0x020` polarity, `0x028` and `0x030` reserved control words, and `0x100`–`0x13F` the vector table with one byte per line.

Within one clock cycle the block applies the events in a fixed order. It first takes the input-line changes, then the effect of the register write. Each dispatch evaluation serves at most one line, which is the lowest-numbered candidate.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset the mask reads all ones, edge select, polarity, status and every vector entry read zero, and all parent outputs are low.
- R2: On a level line (edge bit 0), pending follows the input. If the line is unmasked, a rising input sets its in-service bit and raises parent output `vector[line]` on the following clock edge. A falling input clears the in-service bit and lowers that output.
- R3: On an edge line (edge bit 1), pending is set only when the input is high and its last-seen level was low. A falling input leaves pending, in-service and the parent output unchanged. An input that stays high after a clear does not re-pend the line.
- R4: When a mask write unmasks several pending lines, only the lowest-numbered one is put in service and its parent raised. A line that is already unmasked is not re-evaluated by a write that leaves its mask bit unchanged.
- R5: When a mask write masks a line, the line is released only if it is in service and no longer pending. An in-service line whose pending bit is still set keeps its in-service bit and its parent output.
- R6: The status register returns in-service AND NOT mask.
- R7: A write to the clear register acts only on written bits whose edge bit is 1. For those lines it clears pending and in-service, and it lowers the parent output of the lowest-numbered such line that was in service. Written bits of level lines have no effect.
- R8: The mask, edge, polarity and clear words take a low half at offset +0 and a high half at +4, each leaving the other half unchanged. High-half bits act at line positions 32 to 63. A write with address bits [1:0] not zero is ignored.
- R9: A read of a 64-bit register uses address bits [2:0] as a byte offset. It returns the register shifted right by 8 times that offset and then truncated by `rd_size` (0: 1 byte, 1: 2 bytes, 2: 4 bytes, 3: 8 bytes).
- R10: The vector table holds one 8-bit entry per line at `0x100 + line` and is written from `wr_data[7:0]`. Addresses `0x140`–`0x1FF` read zero and ignore writes. An entry at or above the number of parent outputs drives no output.
- R11: The polarity word is stored and read back but does not change how any input is sampled.
- R12: The clear word, the reserved control words and any unmapped address read zero. Writes to the reserved words are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Interrupt request lines, synchronous to clk |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 12 | Write byte address |
| wr_data | input | 32 | Write data word |
| rd_addr | input | 12 | Read byte address |
| rd_size | input | 2 | Read size code: 0/1/2/3 for 1/2/4/8 bytes |
| rd_data | output | 64 | Combinational read data, zero-extended |
| parent_irq | output | NUM_PARENT | Parent interrupt outputs |

## Verification
The assertions assume that `irq_in` is already synchronised to `clk`, so a level seen at one edge is the level compared against the last-seen copy at that same edge. They also assume that a write lasts exactly one cycle, so a clear or mask event is applied once. The stimulus changes inputs and write strobes only at falling clock edges and holds each write for a single cycle. It samples `parent_irq` and `rd_data` at the falling edge after the rising edge that commits the event. Every expected value is counted from that single register stage.

// File: rtl/irc_pkg.sv
package irc_pkg;

    localparam int LINES  = 64;
    localparam int HALF_W = LINES / 2;
    localparam int IDX_W  = $clog2(LINES);
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] A_MASK   = 12'h000;
    localparam logic [ADDR_W-1:0] A_EDGE   = 12'h008;
    localparam logic [ADDR_W-1:0] A_CLEAR  = 12'h010;
    localparam logic [ADDR_W-1:0] A_STATUS = 12'h018;
    localparam logic [ADDR_W-1:0] A_POL    = 12'h020;
    localparam logic [ADDR_W-1:0] A_RSV0   = 12'h028;
    localparam logic [ADDR_W-1:0] A_RSV1   = 12'h030;
    localparam logic [ADDR_W-1:0] A_VEC    = 12'h100;

    typedef enum logic [2:0] {
        RS_MASK,
        RS_EDGE,
        RS_CLEAR,
        RS_STATUS,
        RS_POL,
        RS_RSV,
        RS_NONE
    } reg_sel_e;

    // Map the 8-byte aligned part of an address to a word register.
    function automatic reg_sel_e decode_reg(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] base;
        base = {a[ADDR_W-1:3], 3'b000};
        case (base)
            A_MASK:         return RS_MASK;
            A_EDGE:         return RS_EDGE;
            A_CLEAR:        return RS_CLEAR;
            A_STATUS:       return RS_STATUS;
            A_POL:          return RS_POL;
            A_RSV0, A_RSV1: return RS_RSV;
            default:        return RS_NONE;
        endcase
    endfunction

    // Replace one 32-bit half of a 64-bit word.
    function automatic logic [LINES-1:0] put_half(input logic [LINES-1:0] old,
                                                  input logic [HALF_W-1:0] d,
                                                  input logic hi);
        return hi ? {d, old[HALF_W-1:0]} : {old[LINES-1:HALF_W], d};
    endfunction

endpackage

// File: rtl/irc_lsb_pick.sv
module irc_lsb_pick #(
    parameter  int W  = 64,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);

    always_comb begin
        hit = |req;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/irc_regs.sv
module irc_regs
    import irc_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [HALF_W-1:0]             wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic [1:0]                    rd_size,
    input  logic [LINES-1:0]              isr,
    output logic [LINES-1:0]              rd_data,
    output logic [LINES-1:0]              mask_q,
    output logic [LINES-1:0]              edge_q,
    output logic [LINES-1:0][VEC_W-1:0]   vec_q,
    output logic [LINES-1:0]              unmask_bits,
    output logic [LINES-1:0]              newmask_bits,
    output logic [LINES-1:0]              clr_bits
);

    reg_sel_e         wsel;
    reg_sel_e         rsel;
    logic             aligned;
    logic             hi;
    logic             mask_we;
    logic             edge_we;
    logic             pol_we;
    logic             clr_we;
    logic             vec_we;
    logic             vec_rd;
    logic [LINES-1:0] mask_nx;
    logic [LINES-1:0] pol_q;
    logic [LINES-1:0] rfull;
    logic [LINES-1:0] rshift;

    assign wsel    = decode_reg(wr_addr);
    assign rsel    = decode_reg(rd_addr);
    assign aligned = (wr_addr[1:0] == 2'b00);
    assign hi      = wr_addr[2];
    assign mask_we = wr_en && aligned && (wsel == RS_MASK);
    assign edge_we = wr_en && aligned && (wsel == RS_EDGE);
    assign pol_we  = wr_en && aligned && (wsel == RS_POL);
    assign clr_we  = wr_en && aligned && (wsel == RS_CLEAR);
    assign vec_we  = wr_en && (wr_addr[ADDR_W-1:IDX_W] == A_VEC[ADDR_W-1:IDX_W]);
    assign vec_rd  = (rd_addr[ADDR_W-1:IDX_W] == A_VEC[ADDR_W-1:IDX_W]);
    assign mask_nx = put_half(mask_q, wr_data, hi);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
            edge_q <= '0;
            pol_q  <= '0;
            vec_q  <= '0;
        end else begin
            if (mask_we) mask_q <= mask_nx;
            if (edge_we) edge_q <= put_half(edge_q, wr_data, hi);
            if (pol_we)  pol_q  <= put_half(pol_q, wr_data, hi);
            if (vec_we)  vec_q[wr_addr[IDX_W-1:0]] <= wr_data[VEC_W-1:0];
        end
    end

    // Dispatch events derived from the write in flight.
    assign unmask_bits  = mask_we ? (mask_q & ~mask_nx) : '0;
    assign newmask_bits = mask_we ? (~mask_q & mask_nx) : '0;
    assign clr_bits     = clr_we ? (put_half('0, wr_data, hi) & edge_q) : '0;

    always_comb begin
        unique case (rsel)
            RS_MASK:   rfull = mask_q;
            RS_EDGE:   rfull = edge_q;
            RS_POL:    rfull = pol_q;
            RS_STATUS: rfull = isr & ~mask_q;
            RS_CLEAR, RS_RSV, RS_NONE: rfull = '0;
            default:   rfull = '0;
        endcase
        rshift = rfull >> {rd_addr[2:0], 3'b000};
        unique case (rd_size)
            2'd0:    rd_data = {{(LINES-8){1'b0}}, rshift[7:0]};
            2'd1:    rd_data = {{(LINES-16){1'b0}}, rshift[15:0]};
            2'd2:    rd_data = {{(LINES-32){1'b0}}, rshift[31:0]};
            default: rd_data = rshift;
        endcase
        if (vec_rd) rd_data = {{(LINES-VEC_W){1'b0}}, vec_q[rd_addr[IDX_W-1:0]]};
    end

endmodule

// File: rtl/irc_core.sv
module irc_core
    import irc_pkg::*;
#(
    parameter int NUM_PARENT = 16,
    parameter int VEC_W      = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LINES-1:0]            irq_in,
    input  logic [LINES-1:0]            mask_q,
    input  logic [LINES-1:0]            edge_q,
    input  logic [LINES-1:0][VEC_W-1:0] vec_tbl,
    input  logic [LINES-1:0]            unmask_bits,
    input  logic [LINES-1:0]            newmask_bits,
    input  logic [LINES-1:0]            clr_bits,
    output logic [LINES-1:0]            pend_q,
    output logic [LINES-1:0]            isr_q,
    output logic [LINES-1:0]            last_q,
    output logic [NUM_PARENT-1:0]       par_q
);

    logic [LINES-1:0]      chg, rise, fall;
    logic [LINES-1:0]      pend_a, a_set, a_clr, isr_a;
    logic [LINES-1:0]      rise_cand, fall_cand, r_oh, f_oh, isr_b;
    logic [LINES-1:0]      pend_d, isr_d;
    logic [NUM_PARENT-1:0] par_d;
    logic                  r_hit, f_hit;
    logic [IDX_W-1:0]      r_idx, f_idx;

    // Step 1: input-line changes, each line on its own.
    assign chg    = irq_in ^ last_q;
    assign rise   = chg & irq_in;
    assign fall   = chg & ~irq_in;
    assign pend_a = (pend_q | rise) & ~(fall & ~edge_q);
    assign a_set  = rise & ~mask_q;
    assign a_clr  = fall & isr_q & ~pend_a;
    assign isr_a  = (isr_q | a_set) & ~a_clr;

    // Step 2: rising evaluation over newly unmasked lines.
    assign rise_cand = unmask_bits & pend_a;
    irc_lsb_pick #(.W(LINES)) u_rise (.req(rise_cand), .hit(r_hit), .idx(r_idx));
    assign r_oh  = r_hit ? (LINES'(1) << r_idx) : '0;
    assign isr_b = isr_a | r_oh;

    // Step 3: falling evaluation (newly masked lines or edge clear).
    assign fall_cand = ((newmask_bits & ~pend_a) | clr_bits) & isr_b;
    irc_lsb_pick #(.W(LINES)) u_fall (.req(fall_cand), .hit(f_hit), .idx(f_idx));
    assign f_oh   = f_hit ? (LINES'(1) << f_idx) : '0;
    assign isr_d  = isr_b & ~f_oh & ~clr_bits;
    assign pend_d = pend_a & ~clr_bits;

    // Parent resolution: line events in index order, then write events.
    for (genvar p = 0; p < NUM_PARENT; p++) begin : g_par
        logic nx;
        always_comb begin
            nx = par_q[p];
            for (int i = 0; i < LINES; i++) begin
                if (int'(vec_tbl[i]) == p) begin
                    if (a_set[i]) nx = 1'b1;
                    if (a_clr[i]) nx = 1'b0;
                end
            end
            if (r_hit && int'(vec_tbl[r_idx]) == p) nx = 1'b1;
            if (f_hit && int'(vec_tbl[f_idx]) == p) nx = 1'b0;
        end
        assign par_d[p] = nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            isr_q  <= '0;
            last_q <= '0;
            par_q  <= '0;
        end else begin
            pend_q <= pend_d;
            isr_q  <= isr_d;
            last_q <= irq_in;
            par_q  <= par_d;
        end
    end

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irc_pkg::*;
#(
    parameter int NUM_PARENT = 16,
    parameter int VEC_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [63:0]           irq_in,
    input  logic                  wr_en,
    input  logic [11:0]           wr_addr,
    input  logic [31:0]           wr_data,
    input  logic [11:0]           rd_addr,
    input  logic [1:0]            rd_size,
    output logic [63:0]           rd_data,
    output logic [NUM_PARENT-1:0] parent_irq
);

    logic [LINES-1:0]            mask_w, edge_w, unmask_w, newmask_w, clr_w;
    logic [LINES-1:0]            pend_w, isr_w, last_w;
    logic [LINES-1:0][VEC_W-1:0] vec_w;

    irc_regs #(.VEC_W(VEC_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .rd_size      (rd_size),
        .isr          (isr_w),
        .rd_data      (rd_data),
        .mask_q       (mask_w),
        .edge_q       (edge_w),
        .vec_q        (vec_w),
        .unmask_bits  (unmask_w),
        .newmask_bits (newmask_w),
        .clr_bits     (clr_w)
    );

    irc_core #(.NUM_PARENT(NUM_PARENT), .VEC_W(VEC_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_in       (irq_in),
        .mask_q       (mask_w),
        .edge_q       (edge_w),
        .vec_tbl      (vec_w),
        .unmask_bits  (unmask_w),
        .newmask_bits (newmask_w),
        .clr_bits     (clr_w),
        .pend_q       (pend_w),
        .isr_q        (isr_w),
        .last_q       (last_w),
        .par_q        (parent_irq)
    );

endmodule

// File: rtl/irc_checker.sv
module irc_checker
    import irc_pkg::*;
#(
    parameter int NUM_PARENT = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [LINES-1:0]      irq_in,
    input logic [NUM_PARENT-1:0] parent_irq,
    input logic [LINES-1:0]      pend,
    input logic [LINES-1:0]      isr,
    input logic [LINES-1:0]      last,
    input logic [LINES-1:0]      edge_sel,
    input logic [LINES-1:0]      unmask,
    input logic [LINES-1:0]      clr
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (parent_irq == '0 && isr == '0));

    assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & $past(edge_sel & pend & ~clr)) == $past(edge_sel & pend & ~clr)));

    assert_edge_needs_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & ~$past(pend) & $past(edge_sel) & ~$past(irq_in & ~last)) == '0));

    assert_one_per_unmask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(isr & ~$past(isr) & $past(unmask)) <= 1));

    assert_clear_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((isr & $past(clr)) == '0));

endmodule

bind irq_route_ctrl irc_checker #(.NUM_PARENT(NUM_PARENT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_in     (irq_in),
    .parent_irq (parent_irq),
    .pend       (pend_w),
    .isr        (isr_w),
    .last       (last_w),
    .edge_sel   (edge_w),
    .unmask     (unmask_w),
    .clr        (clr_w)
);

// File: tb/irq_route_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_route_ctrl_tb_top;

    localparam int NP = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [63:0]   irq_in = '0;
    logic          wr_en = 1'b0;
    logic [11:0]   wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [11:0]   rd_addr = '0;
    logic [1:0]    rd_size = '0;
    logic [63:0]   rd_data;
    logic [NP-1:0] parent_irq;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    irq_route_ctrl #(.NUM_PARENT(NP), .VEC_W(8)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_size    (rd_size),
        .rd_data    (rd_data),
        .parent_irq (parent_irq)
    );

    typedef struct packed {
        logic        do_wr;
        logic [11:0] wa;
        logic [31:0] wd;
        logic [11:0] ra;
        logic [1:0]  rs;
        logic [63:0] exp;
        logic [7:0]  req;
    } step_t;

    localparam int NSTEP = 15;
    localparam step_t TBL [NSTEP] = '{
        '{1'b0, 12'h000, 32'h0,        12'h000, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 8'd1},  // R1 mask
        '{1'b0, 12'h000, 32'h0,        12'h008, 2'd3, 64'h0,                   8'd1},  // R1 edge
        '{1'b0, 12'h000, 32'h0,        12'h100, 2'd0, 64'h0,                   8'd1},  // R1 vector
        '{1'b1, 12'h008, 32'h0000_04A0, 12'h008, 2'd2, 64'h04A0,               8'd8},  // R8 low half
        '{1'b1, 12'h00C, 32'h0000_0100, 12'h008, 2'd3, 64'h0000_0100_0000_04A0, 8'd8}, // R8 high half
        '{1'b0, 12'h000, 32'h0,        12'h009, 2'd0, 64'h04,                  8'd9},  // R9 byte offset 1
        '{1'b0, 12'h000, 32'h0,        12'h00C, 2'd1, 64'h0100,                8'd9},  // R9 offset 4, 2 bytes
        '{1'b1, 12'h020, 32'hDEAD_BEEF, 12'h020, 2'd2, 64'hDEAD_BEEF,          8'd11}, // R11 polarity low
        '{1'b1, 12'h024, 32'h1234_5678, 12'h022, 2'd2, 64'h5678_DEAD,          8'd9},  // R9 offset 2 on polarity
        '{1'b1, 12'h028, 32'hFFFF_FFFF, 12'h028, 2'd3, 64'h0,                  8'd12}, // R12 reserved word
        '{1'b0, 12'h000, 32'h0,        12'h0F8, 2'd3, 64'h0,                   8'd12}, // R12 unmapped
        '{1'b1, 12'h13F, 32'h0000_005A, 12'h13F, 2'd0, 64'h5A,                 8'd10}, // R10 last entry
        '{1'b1, 12'h140, 32'h0000_0077, 12'h140, 2'd0, 64'h0,                  8'd10}, // R10 outside table
        '{1'b1, 12'h002, 32'h0000_0000, 12'h000, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 8'd8}, // R8 unaligned ignored
        '{1'b0, 12'h000, 32'h0,        12'h010, 2'd3, 64'h0,                   8'd12}  // R12 clear reads zero
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [1:0] s, output logic [63:0] v);
        rd_addr = a; rd_size = s;
        #0.5;
        v = rd_data;
    endtask

    task automatic drive(input logic [63:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic chk_par(input string tag, input logic [NP-1:0] exp);
        chk(tag, 64'(parent_irq), 64'(exp));
    endtask

    task automatic chk_stat(input string tag, input logic [63:0] exp);
        logic [63:0] v;
        rd(12'h018, 2'd2, v);
        chk(tag, v, exp);
    endtask

    initial begin
        logic [63:0] v;
        logic [63:0] lines;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_par("R1 parents low after reset", '0);

        for (int k = 0; k < NSTEP; k++) begin
            if (TBL[k].do_wr) wr(TBL[k].wa, TBL[k].wd);
            rd(TBL[k].ra, TBL[k].rs, v);
            chk($sformatf("R%0d table step %0d", TBL[k].req, k), v, TBL[k].exp);
        end

        // Vector entries: line3->2, line5->1, line7->3, line10->4, line40->5, line12->200.
        wr(12'h103, 32'd2);
        wr(12'h105, 32'd1);
        wr(12'h107, 32'd3);
        wr(12'h10A, 32'd4);
        wr(12'h128, 32'd5);
        wr(12'h10C, 32'd200);

        // R2 level line 3; polarity bit 3 is 1, sampling unchanged (R11).
        wr(12'h000, 32'hFFFF_EFF7);
        lines = 64'h8;
        drive(lines);
        chk_par("R2 level rise raises parent", 16'h0004);
        chk_stat("R6 status level in service", 64'h8);
        drive(64'h0);
        chk_par("R2 level fall lowers parent", 16'h0000);
        chk_stat("R2 level fall releases", 64'h0);
        lines = 64'h8;
        drive(lines);
        chk_par("R11 polarity does not gate input", 16'h0004);

        // R10 vector entry beyond parent range.
        lines = lines | 64'h1000;
        drive(lines);
        chk_stat("R10 out-of-range entry still in service", 64'h1008);
        chk_par("R10 out-of-range entry drives nothing", 16'h0004);

        // R7 clear ignored for level lines.
        wr(12'h010, 32'h0000_1008);
        chk_par("R7 level bits ignored by clear", 16'h0004);
        chk_stat("R7 level status kept", 64'h1008);

        // R3 edge line 5.
        wr(12'h000, 32'hFFFF_EFD7);
        lines = lines | 64'h20;
        drive(lines);
        chk_par("R3 edge rise raises parent", 16'h0006);
        lines = lines & ~64'h20;
        drive(lines);
        chk_par("R3 edge fall keeps parent", 16'h0006);
        chk_stat("R3 edge fall keeps service", 64'h1028);
        lines = lines | 64'h20;
        drive(lines);
        wr(12'h010, 32'h0000_0020);
        chk_par("R7 edge clear lowers parent", 16'h0004);
        chk_stat("R7 edge clear releases", 64'h1008);
        repeat (3) @(negedge clk);
        chk_par("R3 held-high edge does not re-pend", 16'h0004);
        lines = lines & ~64'h20;
        drive(lines);
        lines = lines | 64'h20;
        drive(lines);
        chk_par("R3 new rise re-dispatches", 16'h0006);

        // R5 masking while still pending.
        wr(12'h000, 32'hFFFF_EFF7);
        chk_par("R5 masked pending line keeps parent", 16'h0006);
        chk_stat("R6 masked line hidden from status", 64'h1008);
        wr(12'h010, 32'h0000_0020);
        chk_par("R7 clear acts on masked edge line", 16'h0004);

        // R4 lowest-index priority on unmask.
        lines = lines | 64'h480;
        drive(lines);
        chk_par("R4 masked edges stay idle", 16'h0004);
        wr(12'h000, 32'hFFFF_EB77);
        chk_par("R4 only lowest line served", 16'h000C);
        chk_stat("R4 status lowest only", 64'h1088);
        wr(12'h000, 32'hFFFF_EF77);
        chk_par("R4 unchanged bit not re-evaluated", 16'h000C);
        wr(12'h000, 32'hFFFF_EB77);
        chk_par("R4 re-unmask serves next line", 16'h001C);
        chk_stat("R4 status both served", 64'h1488);

        // R7 multi-line clear: only lowest parent lowered.
        wr(12'h010, 32'h0000_0480);
        chk_par("R7 lowest parent lowered only", 16'h0014);
        chk_stat("R7 all written edge lines released", 64'h1008);

        // R8 upper-half line 40.
        lines = lines | (64'h1 << 40);
        drive(lines);
        chk_par("R8 upper line masked idle", 16'h0014);
        wr(12'h004, 32'hFFFF_FEFF);
        chk_par("R8 upper half unmask dispatches", 16'h0034);
        rd(12'h01C, 2'd2, v);
        chk("R8 upper status position", v, 64'h100);
        rd(12'h000, 2'd2, v);
        chk("R8 low half unchanged", v, 64'hFFFF_EB77);

        // R1 reset mid-run.
        @(negedge clk);
        irq_in = '0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_par("R1 parents low after second reset", '0);
        chk_stat("R1 status zero after reset", 64'h0);
        rd(12'h000, 2'd3, v);
        chk("R1 mask all ones after reset", v, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(12'h103, 2'd0, v);
        chk("R1 vector zero after reset", v, 64'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule